// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port RAM

This block stores 512 words of 64 data bits. Each word is kept alongside an 8-bit check byte from a Hamming code that corrects one error and detects two. Writes arrive on their own clock. Reads run on a second clock, and each read returns the corrected word, two error flags and a copy of the address that was read. An encoder output shows the check byte for the data currently on the write bus, so the block can also act as a bare encoder.

There are two write-side inputs for testing the checker. One flips data bit 30 in the stored copy. The other flips data bits 30 and 62. In both cases the check byte is computed from the clean data, so a later read sees one or two bad bits. Correction is applied only on the read output. The stored word keeps its fault until it is written again.

The write port has no handshake and accepts a write on every write-clock edge where `wr_en` is high. The read side is a valid/ready stream. A request is accepted on a read-clock edge where `rd_req_valid` and `rd_req_ready` are both high. `rd_req_ready` is high when no result is waiting or when the waiting result is taken in that same cycle. Once a result is shown (`rd_out_valid` high), data, flags and address stay unchanged until a cycle with `rd_out_ready` high.

Top module: `ecc_sdp_ram`

## Requirements
- R1: A word written without injection reads back unchanged, with both error flags low. The result appears on the read-clock edge after the one that accepts the request.
- R2: `wr_check` gives the check byte for `wr_data`. The data bits are placed, in ascending index order, at the Hamming positions 1 to 71 that are not powers of two. Bit i (0 to 6) is the XOR of the data bits whose position has bit i set. Bit 7 is the XOR of all 64 data bits and check bits 0 to 6.
- R3: A write with `wr_inj_single` high and `wr_inj_double` low reads back as the original data, with `rd_err_single` high and `rd_err_double` low.
- R4: A corrected single-bit fault is not repaired in storage. Every later read of that address flags it again, until the address is rewritten.
- R5: A write with `wr_inj_double` high reads back with `rd_err_double` high and `rd_err_single` low. The data is returned uncorrected: the written data with bits 30 and 62 inverted.
- R6: When both inject inputs are high on one write, the result is the double-bit case of R5.
- R7: `rd_addr_echo` equals the address of the request whose data is on `rd_data`, and is valid in the same cycle.
- R8: `rd_err_single` and `rd_err_double` are never high together.
- R9: While `rd_out_valid` is high and `rd_out_ready` is low, `rd_req_ready` is low, and data, flags and echo stay unchanged.
- R10: If one edge writes address A and accepts a read of A, the read returns the contents A held before that write.
- R11: After reset, `rd_out_valid` and both error flags are low and `rd_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write the word on this edge |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_inj_single | input | 1 | Flip stored data bit 30 on this write |
| wr_inj_double | input | 1 | Flip stored data bits 30 and 62 on this write |
| wr_check | output | 8 | Check byte of `wr_data` (encode-only output) |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read side |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be accepted |
| rd_addr | input | 9 | Read address |
| rd_out_valid | output | 1 | Read result present |
| rd_out_ready | input | 1 | Consumer takes the result |
| rd_data | output | 64 | Corrected or passed-through read data |
| rd_err_single | output | 1 | A single-bit fault was corrected |
| rd_err_double | output | 1 | An uncorrectable double-bit fault was found |
| rd_addr_echo | output | 9 | Address of the word on `rd_data` |

## Verification
A write and a read of the same address can land on the same edge. The bench provokes this by loading a known word, then driving a new word and a read of that address together. The result must be the old word. A second read must then return the new word. A held result under back-pressure can also meet a new request in the same cycle. The bench keeps a request pending while `rd_out_ready` is low, checks that the shown word and echo stay frozen, then releases it and checks that the second address follows on the next edge.

// File: rtl/ecc_sdp_pkg.sv
package ecc_sdp_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int POS_MAX = DATA_W + HAM_W;

  function automatic logic is_pow2(input int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of the Hamming positions of all set data bits
  function automatic logic [HAM_W-1:0] ham_fold(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] acc;
    int unsigned k;
    acc = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= POS_MAX; pos++) begin
      if (!is_pow2(pos)) begin
        if (d[k]) acc = acc ^ HAM_W'(pos);
        k++;
      end
    end
    return acc;
  endfunction

  // Data-bit mask selected by a syndrome; zero for check positions
  function automatic logic [DATA_W-1:0] syn_mask(input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] m;
    int unsigned k;
    m = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= POS_MAX; pos++) begin
      if (!is_pow2(pos)) begin
        if (HAM_W'(pos) == syn) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_sdp_enc.sv
module ecc_sdp_enc
  import ecc_sdp_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);
  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = ham_fold(data_i);
    check_o = {(^data_i) ^ (^ham), ham};
  end
endmodule

// File: rtl/ecc_sdp_dec.sv
module ecc_sdp_dec
  import ecc_sdp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  chk;
  logic [HAM_W-1:0]  syn;
  logic              odd;

  always_comb begin
    raw = word_i[DATA_W-1:0];
    chk = word_i[WORD_W-1:DATA_W];
    syn = ham_fold(raw) ^ chk[HAM_W-1:0];
    odd = (^raw) ^ (^chk);
    single_o = odd;
    double_o = !odd && (syn != '0);
    if (odd) data_o = raw ^ syn_mask(syn);
    else     data_o = raw;
  end
endmodule

// File: rtl/ecc_sdp_store.sv
module ecc_sdp_store
  import ecc_sdp_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  // All-zero word is a valid codeword, so reset leaves the decoder clean
  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)  rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram
  import ecc_sdp_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int INJ_A  = 30,
  parameter int INJ_B  = 62
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_inj_single,
  input  logic              wr_inj_double,
  output logic [CHK_W-1:0]  wr_check,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err_single,
  output logic              rd_err_double,
  output logic [ADDR_W-1:0] rd_addr_echo
);
  logic [DATA_W-1:0] flip;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] held_word;
  logic              dec_single;
  logic              dec_double;
  logic              out_q;
  logic [ADDR_W-1:0] echo_q;
  logic              fire;

  ecc_sdp_enc u_enc (
    .data_i  (wr_data),
    .check_o (wr_check)
  );

  // Double takes precedence: both inputs high still flips two bits
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_flip
      if (b == INJ_A) begin : g_a
        assign flip[b] = wr_inj_single | wr_inj_double;
      end else if (b == INJ_B) begin : g_b
        assign flip[b] = wr_inj_double;
      end else begin : g_n
        assign flip[b] = 1'b0;
      end
    end
  endgenerate

  assign wr_word = {wr_check, wr_data ^ flip};

  assign rd_req_ready = !out_q || rd_out_ready;
  assign fire = rd_req_valid && rd_req_ready;

  ecc_sdp_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  (wr_word),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (fire),
    .rd_addr  (rd_addr),
    .rd_word  (held_word)
  );

  ecc_sdp_dec u_dec (
    .word_i   (held_word),
    .data_o   (rd_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      out_q  <= 1'b0;
      echo_q <= '0;
    end else begin
      if (fire)              out_q <= 1'b1;
      else if (rd_out_ready) out_q <= 1'b0;
      if (fire) echo_q <= rd_addr;
    end
  end

  assign rd_out_valid  = out_q;
  assign rd_addr_echo  = echo_q;
  assign rd_err_single = out_q && dec_single;
  assign rd_err_double = out_q && dec_double;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_err_single && rd_err_double)); // R8
  AST_HOLD_UNDER_STALL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_out_valid && !rd_out_ready |=> rd_out_valid && $stable(rd_data) && $stable(rd_addr_echo)); // R9
  AST_STALL_BLOCKS_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_out_valid && !rd_out_ready |-> !rd_req_ready); // R9
  AST_ECHO_FOLLOWS: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_req_valid && rd_req_ready |=> rd_out_valid && rd_addr_echo == $past(rd_addr)); // R7
  AST_DOUBLE_RAW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_err_double |-> rd_data == held_word[DATA_W-1:0]); // R5
  AST_CLEAN_RAW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_out_valid && !rd_err_single && !rd_err_double |-> rd_data == held_word[DATA_W-1:0]); // R1
endmodule

// File: tb/ecc_sdp_ram_tb_top.sv
`timescale 1ns/1ps
module ecc_sdp_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        inj_s = 1'b0, inj_d = 1'b0;
  logic [7:0]  wr_check;
  logic        req_valid = 1'b0, req_ready;
  logic [8:0]  rd_addr = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] rd_data;
  logic        e_s, e_d;
  logic [8:0]  echo;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ecc_sdp_ram dut_i (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_inj_single(inj_s), .wr_inj_double(inj_d), .wr_check(wr_check),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_req_valid(req_valid), .rd_req_ready(req_ready),
    .rd_addr(rd_addr), .rd_out_valid(out_valid), .rd_out_ready(out_ready),
    .rd_data(rd_data), .rd_err_single(e_s), .rd_err_double(e_d), .rd_addr_echo(echo)
  );

  // Entries: {addr, data, inj_single, inj_double}
  localparam int NV = 8;
  localparam logic [74:0] VEC [NV] = '{
    {9'd0,   64'h0000_0000_0000_0000, 1'b0, 1'b0},
    {9'd511, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
    {9'd5,   64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0},
    {9'd17,  64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b1},
    {9'd100, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b1},
    {9'd200, 64'h8000_0000_0000_0001, 1'b0, 1'b0},
    {9'd300, 64'h4000_0000_4000_0000, 1'b1, 1'b0},
    {9'd44,  64'h0123_4567_89AB_CDEF, 1'b0, 1'b1}
  };
  localparam logic [63:0] DMASK = 64'h4000_0000_4000_0000;

  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] h = '0;
    int k = 0;
    for (int pos = 1; pos <= 71; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[k]) h = h ^ 7'(pos);
        k++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [63:0] d, input logic s, input logic x);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; inj_s = s; inj_d = x;
    #1 check("R2 check byte", 64'(wr_check), 64'(ref_chk(d)));
    @(negedge clk);
    wr_en = 1'b0; inj_s = 1'b0; inj_d = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a);
    @(negedge clk);
    req_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid", 64'(out_valid), 0);
    check("R11 flags", {62'b0, e_s, e_d}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 req_ready", 64'(req_ready), 1);
    check("R11 out_valid after release", 64'(out_valid), 0);

    for (int i = 0; i < NV; i++)
      do_write(VEC[i][74:66], VEC[i][65:2], VEC[i][1], VEC[i][0]);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] d;
      logic s, x;
      d = VEC[i][65:2]; s = VEC[i][1]; x = VEC[i][0];
      do_read(VEC[i][74:66]);
      check("R1 R7 valid and echo", {54'b0, out_valid, echo}, {54'b0, 1'b1, VEC[i][74:66]});
      check("R8 flags not both", 64'(e_s && e_d), 0);
      if (x) begin
        check("R5 R6 raw data", rd_data, d ^ DMASK);
        check("R5 R6 flags", {62'b0, e_s, e_d}, 64'b01);
      end else if (s) begin
        check("R3 corrected data", rd_data, d);
        check("R3 flags", {62'b0, e_s, e_d}, 64'b10);
      end else begin
        check("R1 data", rd_data, d);
        check("R1 flags", {62'b0, e_s, e_d}, 0);
      end
    end

    // R4: fault remains in storage
    do_read(9'd5);
    check("R4 reflag single", {62'b0, e_s, e_d}, 64'b10);
    check("R4 data", rd_data, 64'h1234_5678_9ABC_DEF0);
    do_write(9'd5, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0);
    do_read(9'd5);
    check("R4 clean after rewrite", {62'b0, e_s, e_d}, 0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0; req_valid = 1'b1; rd_addr = 9'd200;
    @(negedge clk);
    check("R9 first shown", rd_data, 64'h8000_0000_0000_0001);
    check("R9 req_ready low", 64'(req_ready), 0);
    rd_addr = 9'd511;
    @(negedge clk);
    check("R9 data held", rd_data, 64'h8000_0000_0000_0001);
    check("R9 echo held", 64'(echo), 64'd200);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next data", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 next echo", 64'(echo), 64'd511);
    @(negedge clk);
    check("R9 drained", 64'(out_valid), 0);

    // R10: same-edge write and read of one address
    do_write(9'd77, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'd77; wr_data = 64'h5555_6666_7777_8888;
    req_valid = 1'b1; rd_addr = 9'd77;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R10 old contents", rd_data, 64'h1111_2222_3333_4444);
    do_read(9'd77);
    check("R10 new contents", rd_data, 64'h5555_6666_7777_8888);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule